// File: doc/BRIEF.md
# Short Signature Lookup Matcher

This block scans a byte stream for signatures that are one or two bytes long, with no hashing. Each accepted byte indexes a byte table. The entry gives a single-byte hit flag and a short compression code for that byte. The code of the byte before it and the code of the current byte are joined into an address for a pair table. That table holds one bit per address, and the bit marks a two-byte hit ending at the current byte.

A small set of distinct bytes takes part in two-byte signatures, so every such byte can be named with a few bits. Code zero is reserved for bytes that belong to no pair signature, and any lookup that involves code zero never reports a pair. The first byte of a packet, marked by a start-of-packet flag, has no predecessor, so it cannot complete a pair. Both tables are written through a plain load port.

The byte input is a valid/ready stream. The result stream has one beat per input beat, in the same order, and the beat appears one cycle after the input byte is accepted. The result port has one register stage. While a result is held because `out_ready` is low, `in_ready` is low, and the held result does not change. A new byte is accepted in the same cycle that the held result drains.

Top module: `short_sig_matcher`

## Requirements
- R1: For every accepted byte b, `match_single` of its result beat equals bit CODE_W (the top bit) of byte-table entry b.
- R2: The pair-table address is {code of previous accepted byte, code of current byte}, with the previous code in the upper CODE_W bits. The code of a byte is bits CODE_W-1:0 of its entry. `match_pair` equals the bit stored at that address, unless R3 or R4 suppresses it.
- R3: `match_pair` is 0 for a byte accepted with `in_sop` high. It is also 0 for the first byte accepted after reset.
- R4: When the previous or the current code equals 0, `match_pair` is 0, whatever the pair table holds at that address.
- R5: Each accepted byte yields exactly one result beat. The beat has `out_valid` high from the cycle after acceptance, and beats keep input order.
- R6: While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold. `in_ready` equals `out_ready` or not `out_valid`.
- R7: Reset clears `out_valid` and both tables, so no hit is reported until the tables are loaded.
- R8: A cycle with `cfg_we` high and `cfg_sel`=0 writes `cfg_data` to byte-table entry `cfg_addr[BYTE_W-1:0]`. A cycle with `cfg_we` high and `cfg_sel`=1 writes `cfg_data[0]` to pair-table entry `cfg_addr[2*CODE_W-1:0]`. The write affects bytes accepted in later cycles.
- R9: The previous code changes only when a byte is accepted. A pair can therefore complete across idle or stalled cycles inside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte can be accepted |
| in_byte | input | BYTE_W | Stream byte |
| in_sop | input | 1 | Byte is the first of a packet |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes result beat |
| match_single | output | 1 | Single-byte signature hit |
| match_pair | output | 1 | Two-byte signature ends at this byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = byte table, 1 = pair table |
| cfg_addr | input | max(BYTE_W, 2*CODE_W) | Table entry index |
| cfg_data | input | CODE_W+1 | {hit, code} for byte table; bit 0 for pair table |

## Verification
The bench builds the block with the default BYTE_W=8 and CODE_W=6. At that size, all 256 byte entries and all 4096 pair entries can be loaded and then read back through the stream. The bench writes every pair address, including those that use the reserved code, and then sends every byte value once. It also sends every ordered pair of the 50 coded bytes, so each populated pair-table location is reached. Random packet streams with random consumer stalls then exercise start-of-packet suppression, pairs that complete across gaps, and holding under back-pressure.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  // Selects which table the load port writes.
  typedef enum logic {
    TGT_BYTE = 1'b0,
    TGT_PAIR = 1'b1
  } ssm_tgt_e;
endpackage

// File: rtl/ssm_lut.sv
module ssm_lut #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Reset clears every entry (R7); writes land at the clock edge (R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ssm_pair_ctx.sv
module ssm_pair_ctx #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              sop,
  input  logic [CODE_W-1:0] cur_code,
  output logic [CODE_W-1:0] prev_code,
  output logic              pair_ok
);
  logic prev_seen;

  // The previous code moves only on an accepted byte (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= '0;
      prev_seen <= 1'b0;
    end else if (adv) begin
      prev_code <= cur_code;
      prev_seen <= 1'b1;
    end
  end

  // A pair is allowed only with a real predecessor, outside packet start,
  // and with neither code being the reserved value (R3, R4).
  assign pair_ok = prev_seen && !sop && (prev_code != '0) && (cur_code != '0);

  assert_ctx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(prev_code));
  assert_ctx_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (prev_code == $past(cur_code)));
endmodule

// File: rtl/ssm_out_stage.sv
module ssm_out_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = out_ready || !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && (out_data == $past(in_data))));
  assert_reset_empty_R7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: rtl/short_sig_matcher.sv
module short_sig_matcher
  import ssm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 6,
  localparam int ENT_W   = CODE_W + 1,
  localparam int PAIR_AW = 2 * CODE_W,
  localparam int CFG_AW  = (BYTE_W > PAIR_AW) ? BYTE_W : PAIR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_sop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              match_single,
  output logic              match_pair,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ENT_W-1:0]  cfg_data
);
  logic [ENT_W-1:0]  byte_ent;
  logic [CODE_W-1:0] cur_code;
  logic [CODE_W-1:0] prev_code;
  logic              cur_hit;
  logic              pair_bit;
  logic              pair_ok;
  logic              accept;
  logic              we_byte;
  logic              we_pair;
  logic [1:0]        res_in;
  logic [1:0]        res_out;

  assign we_byte = cfg_we && (ssm_tgt_e'(cfg_sel) == TGT_BYTE);
  assign we_pair = cfg_we && (ssm_tgt_e'(cfg_sel) == TGT_PAIR);
  assign accept  = in_valid && in_ready;

  // Byte table: {hit, code} per byte value (R1, R8).
  ssm_lut #(.ADDR_W(BYTE_W), .DATA_W(ENT_W)) u_byte_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_byte),
    .waddr (cfg_addr[BYTE_W-1:0]),
    .wdata (cfg_data),
    .raddr (in_byte),
    .rdata (byte_ent)
  );

  assign cur_code = byte_ent[CODE_W-1:0];
  assign cur_hit  = byte_ent[CODE_W];

  // Pair table: one bit per {previous code, current code} (R2, R8).
  ssm_lut #(.ADDR_W(PAIR_AW), .DATA_W(1)) u_pair_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_pair),
    .waddr (cfg_addr[PAIR_AW-1:0]),
    .wdata (cfg_data[0]),
    .raddr ({prev_code, cur_code}),
    .rdata (pair_bit)
  );

  ssm_pair_ctx #(.CODE_W(CODE_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (accept),
    .sop       (in_sop),
    .cur_code  (cur_code),
    .prev_code (prev_code),
    .pair_ok   (pair_ok)
  );

  assign res_in = {cur_hit, pair_bit && pair_ok};

  ssm_out_stage #(.W(2)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign match_single = res_out[1];
  assign match_pair   = res_out[0];

  assert_sop_no_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sop) |=> !match_pair);
  assert_reserved_no_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cur_code == '0)) |=> !match_pair);
endmodule

// File: tb/short_sig_matcher_bench.sv
module short_sig_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        in_sop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        match_single;
  logic        match_pair;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [6:0]  cfg_data = '0;

  always #5 clk = ~clk;

  short_sig_matcher #(.BYTE_W(8), .CODE_W(6)) u_short_sig_matcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_sop(in_sop), .out_valid(out_valid),
    .out_ready(out_ready), .match_single(match_single), .match_pair(match_pair),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Shadow of what the bench has written (R7: zero after reset).
  bit       mdl_hit  [256];
  bit [5:0] mdl_code [256];
  bit       mdl_pair [4096];

  bit exp_s [16384];
  bit exp_p [16384];
  int q_head = 0;
  int q_tail = 0;
  int b_prev = 0;
  bit b_prev_ok = 0;
  bit stall_on = 0;

  function automatic int code_of(int b);
    if ((b % 5 == 0) && (b < 250)) return b / 5 + 1;
    return 0;
  endfunction

  function automatic bit pair_fn(int c1, int c2);
    return ((c1 + 2 * c2) % 11) == 0;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive, observe the handshakes of the coming edge, advance.
  task automatic tick(bit v, int d, bit s, output bit acc);
    int pa;
    bit ep;
    in_valid  = v;
    in_byte   = d[7:0];
    in_sop    = s;
    out_ready = stall_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    #1;
    check(in_ready == (out_ready || !out_valid), "R6 in_ready", int'(in_ready),
          int'(out_ready || !out_valid));
    if (out_valid && out_ready) begin
      if (q_head == q_tail) begin
        check(0, "R5 extra beat", 1, 0);
      end else begin
        check(match_single == exp_s[q_head & 16383], "R1 single",
              int'(match_single), int'(exp_s[q_head & 16383]));
        check(match_pair == exp_p[q_head & 16383], "R2/R3/R4 pair",
              int'(match_pair), int'(exp_p[q_head & 16383]));
        q_head++;
      end
    end
    acc = v && in_ready;
    if (acc) begin
      pa = {mdl_code[b_prev], mdl_code[d]};
      ep = !s && b_prev_ok && (mdl_code[b_prev] != 0) && (mdl_code[d] != 0) && mdl_pair[pa];
      exp_s[q_tail & 16383] = mdl_hit[d];
      exp_p[q_tail & 16383] = ep;
      q_tail++;
      b_prev = d;
      b_prev_ok = 1;
    end
    @(negedge clk);
  endtask

  task automatic push(int d, bit s);
    bit acc;
    do tick(1'b1, d, s, acc); while (!acc);
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(1'b0, 0, 1'b0, acc);
  endtask

  task automatic drain();
    bit acc;
    stall_on = 0;
    for (int i = 0; i < 8 && q_head != q_tail; i++) tick(1'b0, 0, 1'b0, acc);
    check(q_head == q_tail, "R5 beats drained", q_tail - q_head, 0);
  endtask

  task automatic cfg_write(bit sel, int a, int dat);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a[11:0]; cfg_data = dat[6:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) begin
      mdl_hit[a & 255]  = dat[6];
      mdl_code[a & 255] = dat[5:0];
    end else begin
      mdl_pair[a] = dat[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(out_valid == 1'b0, "R7 out_valid reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R7 in_ready reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: empty tables give no hit; R3: first byte after reset has no predecessor
    push(3, 0);
    push(10, 0);
    drain();

    // R8: load byte table {hit at bit 6, code at bits 5:0}
    for (int b = 0; b < 256; b++)
      cfg_write(1'b0, b, ((b % 7 == 3) ? 64 : 0) + code_of(b));
    // R8 / R4: every pair address; reserved-code addresses are loaded with 1
    for (int a = 0; a < 4096; a++)
      cfg_write(1'b1, a, ((a >> 6) == 0 || (a & 63) == 0) ? 1 : int'(pair_fn(a >> 6, a & 63)));

    // R1, R2, R4: every byte value in one packet
    push(0, 1);
    for (int b = 1; b < 256; b++) push(b, 0);
    drain();

    // R2, R3: every ordered pair of coded bytes, with stalls (R6)
    stall_on = 1;
    for (int i = 0; i < 50; i++)
      for (int j = 0; j < 50; j++) begin
        push(i * 5, 1);
        push(j * 5, 0);
      end
    drain();

    // R9: pair across idle cycles (codes 9 then 1 form a pair)
    push(40, 1);
    idle(3);
    push(0, 0);
    // R3: same bytes but second starts a new packet
    push(40, 0);
    push(0, 1);
    drain();

    // R8, R4: recode byte 40 to reserved code 0 with hit set
    cfg_write(1'b0, 40, 64);
    push(40, 1);
    push(0, 0);
    push(0, 0);
    drain();

    // Random packets with stalls and gaps (R1..R6, R9)
    stall_on = 1;
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(0, 9) == 0) idle(1);
      push(($urandom_range(0, 1) == 0) ? 5 * $urandom_range(0, 49) : $urandom_range(0, 255),
           $urandom_range(0, 7) == 0);
    end
    drain();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule